// File: doc/BRIEF.md
# Signed Sample Requantizer with Error Feedback

This block narrows a wide signed two's complement sample to a shorter signed width, for example between a filter and a stage that only accepts a fixed input width. The narrowing step can use one of three policies, picked by a static mode input:

- plain truncation, which always goes toward minus infinity and so adds a DC bias;
- nearest rounding, where an exact half-step tie goes to the even neighbour;
- truncation with a carried residue, where the low bits thrown away from one sample are added to the next valid sample before it is cut.

Whenever rounding or the carried residue would push a result outside the output range, the result is clamped to the largest or smallest output code. A flag marks each sample that was clamped. Results are registered and appear one clock after their input, with a matching valid strobe.

Top module: `rq_requant`

## Requirements
- R1: While reset is asserted, and after it is released with no valid input, out_valid, out_data and out_sat are all zero.
- R2: In mode 0 (truncate), out_data is the input's upper OUT_W bits (bits IN_W-1 down to IN_W-OUT_W), i.e. floor(in_data / 2^(IN_W-OUT_W)), and out_sat is 0.
- R3: In mode 1 (round), the result is the nearest multiple of the step 2^(IN_W-OUT_W), expressed in steps. An exact half-step tie resolves to the neighbour whose least significant bit is 0.
- R4: In mode 2 (feedback), the stored residue r is added to the input. The result is floor((in_data + r) / 2^(IN_W-OUT_W)), and the new residue is (in_data + r) mod 2^(IN_W-OUT_W). This holds even when the result is then clamped.
- R5: Any result above 2^(OUT_W-1)-1 is output as that value, and any result below -2^(OUT_W-1) is output as that value. In both cases out_sat is 1 for that sample; otherwise out_sat is 0.
- R6: out_valid equals in_valid delayed by exactly one clock.
- R7: On every clock with the mode not equal to 2, the residue becomes zero, so a feedback run always starts from a zero residue. Mode 3 behaves as mode 0.
- R8: A clock with in_valid low leaves the residue, out_data and out_sat unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Wide signed sample |
| mode | input | 2 | 0 truncate, 1 round half to even, 2 residue feedback, 3 truncate |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Narrowed signed sample |
| out_sat | output | 1 | The sample was clamped to a range limit |

## Verification
The assertions assume that mode is driven from the same clock, so it is stable at each sampling edge. They also assume that in_data is fully known whenever in_valid is high. The bench changes every input only at the falling edge and always drives defined values, including on idle cycles. Feedback runs are broken up by single truncation or rounding cycles, so the residue-clearing path is exercised while samples are still arriving. Values at the range limits and at exact half-step ties are mixed in on purpose, so clamping and tie handling occur in every mode.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    RQ_TRUNC = 2'd0,
    RQ_ROUND = 2'd1,
    RQ_FDBK  = 2'd2,
    RQ_ALT   = 2'd3
  } rq_mode_e;
endpackage

// File: rtl/rq_quantize.sv
module rq_quantize
  import rq_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]             sample,
  input  logic [1:0]                  mode,
  input  logic [IN_W-OUT_W:0]         residue,
  output logic signed [OUT_W+1:0]     quot,
  output logic [IN_W-OUT_W-1:0]       frac
);
  localparam int DROP_W = IN_W - OUT_W;
  localparam int WIDE_W = IN_W + 2;
  localparam int QW     = OUT_W + 2;
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] sum;
  logic [QW-1:0]            floor_q;
  logic                     bump;

  always_comb begin
    sum = {{2{sample[IN_W-1]}}, sample};
    if (rq_mode_e'(mode) == RQ_FDBK)
      sum = sum + {{(WIDE_W-DROP_W-1){1'b0}}, residue};
    floor_q = sum[WIDE_W-1:DROP_W];
    frac    = sum[DROP_W-1:0];
    bump    = (rq_mode_e'(mode) == RQ_ROUND) &&
              ((frac > HALF) || ((frac == HALF) && floor_q[0]));
    quot    = $signed(floor_q + {{(QW-1){1'b0}}, bump});
  end
endmodule

// File: rtl/rq_saturate.sv
module rq_saturate #(
  parameter int OUT_W = 8
) (
  input  logic signed [OUT_W+1:0] quot,
  output logic [OUT_W-1:0]        data,
  output logic                    sat
);
  localparam int QW = OUT_W + 2;
  localparam logic signed [QW-1:0] MAX_Q = {3'b000, {(OUT_W-1){1'b1}}};
  localparam logic signed [QW-1:0] MIN_Q = {3'b111, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (quot > MAX_Q) begin
      data = {1'b0, {(OUT_W-1){1'b1}}};
      sat  = 1'b1;
    end else if (quot < MIN_Q) begin
      data = {1'b1, {(OUT_W-1){1'b0}}};
      sat  = 1'b1;
    end else begin
      data = quot[OUT_W-1:0];
      sat  = 1'b0;
    end
  end
endmodule

// File: rtl/rq_residue.sv
module rq_residue
  import rq_pkg::*;
#(
  parameter int RES_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [1:0]       mode,
  input  logic [RES_W-2:0] frac,
  output logic [RES_W-1:0] res_q
);
  logic [RES_W-1:0] res_d;
  logic             res_en;

  always_comb begin
    res_en = 1'b0;
    res_d  = res_q;
    if (rq_mode_e'(mode) != RQ_FDBK) begin
      res_en = 1'b1;
      res_d  = '0;
    end else if (take) begin
      res_en = 1'b1;
      res_d  = {1'b0, frac};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end
endmodule

// File: rtl/rq_requant.sv
module rq_requant #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_sat
);
  localparam int DROP_W = IN_W - OUT_W;
  localparam int RES_W  = DROP_W + 1;

  logic signed [OUT_W+1:0] quot;
  logic [DROP_W-1:0]       frac;
  logic [RES_W-1:0]        res_q;
  logic [OUT_W-1:0]        sat_data;
  logic                    sat_flag;

  logic             valid_d, sat_d;
  logic [OUT_W-1:0] data_d;

  rq_quantize #(.IN_W(IN_W), .OUT_W(OUT_W)) quant_i (
    .sample(in_data), .mode(mode), .residue(res_q), .quot(quot), .frac(frac)
  );

  rq_saturate #(.OUT_W(OUT_W)) clamp_i (
    .quot(quot), .data(sat_data), .sat(sat_flag)
  );

  rq_residue #(.RES_W(RES_W)) resid_i (
    .clk(clk), .rst_n(rst_n), .take(in_valid), .mode(mode),
    .frac(frac), .res_q(res_q)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = out_data;
    sat_d   = out_sat;
    if (in_valid) begin
      data_d = sat_data;
      sat_d  = sat_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_sat  <= 1'b0;
    end else if (in_valid) begin
      out_data <= data_d;
      out_sat  <= sat_d;
    end
  end
endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic [1:0]       mode,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_sat,
  input logic [IN_W-OUT_W:0] res_q
);
  localparam logic [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_sat)));
  a_r5_clamp_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> (out_data == TOP || out_data == BOT));
  a_r2_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=>
      (out_data == $past(in_data[IN_W-1:IN_W-OUT_W]) && !out_sat));
  a_r7_residue_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |=> (res_q == '0));
  a_r8_residue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && mode == 2'd2) |=> $stable(res_q));
  a_r4_residue_msb: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> !res_q[IN_W-OUT_W]);
endmodule

bind rq_requant rq_requant_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .mode(mode), .out_valid(out_valid), .out_data(out_data),
  .out_sat(out_sat), .res_q(res_q)
);

// File: tb/rq_requant_tb.sv
module rq_requant_tb_top;
  localparam int IN_W  = 16;
  localparam int OUT_W = 8;
  localparam int D     = IN_W - OUT_W;
  localparam int STEP  = 1 << D;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic [1:0]       mode = 2'd0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic             out_sat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int    m_res = 0;
  int    e_valid = 0, e_data = 0, e_sat = 0;
  string e_tag = "R1";
  int    prev_mode = 0;

  always #2 clk = ~clk;

  rq_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(out_valid == e_valid[0], "R6", int'(out_valid), e_valid);
    check(int'(out_data) == (e_data & (1 << OUT_W) - 1), e_tag,
          int'(out_data), e_data & ((1 << OUT_W) - 1));
    check(out_sat == e_sat[0], "R5", int'(out_sat), e_sat);
  endtask

  // apply one input at a falling edge; compare the previous result first
  task automatic step(input bit v, input int x, input int md);
    int q, frac, s, hi, lo;
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_data  = IN_W'(x);
    mode     = 2'(md);
    hi = (1 << (OUT_W - 1)) - 1;
    lo = -(1 << (OUT_W - 1));
    if (v) begin
      s = x;
      if (md == 2) s = x + m_res;
      q    = s >>> D;
      frac = s & (STEP - 1);
      if (md == 1 && (frac > STEP / 2 || (frac == STEP / 2 && (q & 1) == 1))) q = q + 1;
      e_sat = 0;
      if (q > hi) begin q = hi; e_sat = 1; end
      if (q < lo) begin q = lo; e_sat = 1; end
      e_data = q;
      if (md == 1)      e_tag = "R3";
      else if (md == 2) e_tag = (prev_mode != 2) ? "R7" : "R4";
      else if (md == 3) e_tag = "R7";
      else              e_tag = "R2";
      if (md == 2) m_res = frac;
    end else begin
      e_tag = "R8";
    end
    if (md != 2) m_res = 0;
    e_valid = v;
    prev_mode = md;
  endtask

  function automatic int pick_value();
    int r;
    r = int'($urandom_range(0, 9));
    case (r)
      0: return 32767;
      1: return -32768;
      2: return (int'($urandom_range(0, 255)) - 128) * STEP + STEP / 2;
      3: return 32767 - int'($urandom_range(0, 300));
      4: return -32768 + int'($urandom_range(0, 300));
      default: return int'($urandom_range(0, 65535)) - 32768;
    endcase
  endfunction

  initial begin
    void'($urandom(1234));
    #1;
    // R1: outputs zero under reset
    check(out_valid == 1'b0 && out_data == '0 && out_sat == 1'b0, "R1",
          int'(out_data), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_valid = 0; e_data = 0; e_sat = 0; e_tag = "R1";
    step(0, 0, 0);
    step(0, 0, 0);
    // R2 directed: -1 truncates to -1, 0x7FFF to 127
    step(1, -1, 0);
    step(1, 32767, 0);
    // R3 ties: 0.5 -> 0, 1.5 -> 2, -0.5 -> 0, -1.5 -> -2, overflow near top
    step(1, STEP / 2, 1);
    step(1, STEP + STEP / 2, 1);
    step(1, -STEP / 2, 1);
    step(1, -STEP - STEP / 2, 1);
    step(1, 32767, 1);
    // R4/R5 feedback run near the top, with idle gaps (R8)
    step(1, 32767, 2);
    step(1, 32767, 2);
    step(0, 12345, 2);
    step(1, 200, 2);
    step(1, -32768, 2);
    // R7 interruption and mode 3
    step(1, 300, 3);
    step(1, 100, 2);
    step(0, 0, 1);
    step(1, 100, 2);
    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      int md;
      md = (i / 500) % 4;
      if ($urandom_range(0, 19) == 0) md = int'($urandom_range(0, 3));
      step($urandom_range(0, 3) != 0, pick_value(), md);
    end
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule